// File: doc/BRIEF.md
# Privileged System Register Access Unit

This block holds the system state of a 32-bit core that only privileged code may touch: three mode and paging control registers and six debug registers. The execute stage presents one move request per cycle. The request gives a register class (control or debug), an architectural register number from 0 to 7, a direction and the current privilege level. For a read, the block returns the selected register's value in the same cycle. For a write, it commits the general-register operand on the next clock edge.

Illegal accesses raise one of two fault flags in the same cycle as the request, and no state changes. The checks are:

- the privilege level;
- whether the requested control register exists;
- a lockout bit held in the debug-control register;
- forbidden bit combinations in the mode-control register.

On accepted writes to the debug-status and debug-control registers, the block forces their reserved bits to fixed values. The surrounding pipeline turns the fault flags into exceptions.

Top module: `sysreg_access_unit`

## Requirements
- R1: A valid request whose privilege level is not 0 raises `flt_gp`, never `flt_ud`, returns 0 and changes no register. This check takes priority over every other check.
- R2: At privilege 0, a control-class access (`req_dbg`=0) to register number 1, 4, 5, 6 or 7 raises `flt_ud`, returns 0 and changes no register.
- R3: Control numbers 0, 2 and 3 select three distinct storage registers. A write to one is read back from that number and leaves the other two unchanged.
- R4: Debug numbers 0 to 5 select six distinct storage registers. Debug numbers 6 and 7 reach the same storage as numbers 4 and 5.
- R5: While bit 13 of the debug-control register (debug number 5) is 1, every debug-class read or write at privilege 0 raises `flt_gp` and changes nothing. Control-class accesses are unaffected.
- R6: A write to control register 0 with bit 31 set and bit 0 clear raises `flt_gp` and leaves the register unchanged.
- R7: A write to control register 0 with bit 29 set and bit 30 clear raises `flt_gp` and leaves the register unchanged.
- R8: After an accepted write to the debug-status register (debug number 4 or 6), it holds the written value OR 0xFFFF1FF0.
- R9: After an accepted write to the debug-control register (debug number 5 or 7), it holds the written value AND NOT 0x0000DC00.
- R10: After reset every register reads 0, except the debug-status register, which reads 0xFFFF1FF0.
- R11: A legal read returns data in the same cycle and leaves no register changed. A legal write changes only its target, and only at the next rising clock edge. Without `req_vld`, both fault flags are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = move into the register, 0 = move out of it |
| req_dbg | input | 1 | Register class: 0 = control, 1 = debug |
| req_num | input | 3 | Architectural register number |
| req_cpl | input | 2 | Current privilege level |
| wr_data | input | 32 | Operand from the general register file |
| rd_data | output | 32 | Read value (0 on fault or when not reading) |
| flt_gp | output | 1 | General-protection fault |
| flt_ud | output | 1 | Undefined-opcode fault |

## Verification
The bench builds the block with its default 32-bit data path. In that configuration the register space is 2 classes by 8 numbers by 4 privilege levels by 2 directions, so the bench sweeps every combination against a bench-side model of the nine registers. Write patterns are chosen to hit each forbidden mode-control bit pairing and each reserved-bit mask. The lockout bit is set last, because it can never be cleared afterwards. The final sweep therefore confirms that every debug access faults while control accesses still work.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_W    = 3;
  localparam int CPL_W    = 2;
  localparam int NUM_CR   = 3;
  localparam int NUM_DR   = 6;
  localparam int SLOT_W   = $clog2(NUM_DR);

  localparam int DR_STAT_SLOT = 4;
  localparam int DR_CTRL_SLOT = 5;
  localparam int GD_BIT       = 13;

  localparam int CR0_PE = 0;
  localparam int CR0_NW = 29;
  localparam int CR0_CD = 30;
  localparam int CR0_PG = 31;

  localparam logic [DATA_W-1:0] STAT_ONES_MASK = 32'hFFFF_1FF0;
  localparam logic [DATA_W-1:0] CTRL_ZERO_MASK = 32'h0000_DC00;

  typedef enum logic { CLS_CTRL = 1'b0, CLS_DBG = 1'b1 } reg_class_e;
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic              vld,
  input  logic              wr,
  input  reg_class_e        cls,
  input  logic [NUM_W-1:0]  num,
  input  logic [CPL_W-1:0]  cpl,
  input  logic              gd_lock,
  input  logic              cr0_bad,
  output logic [SLOT_W-1:0] slot,
  output logic              gp,
  output logic              ud
);
  logic cr_exists;
  logic priv_bad;

  always_comb begin
    cr_exists = (num == 3'd0) || (num == 3'd2) || (num == 3'd3);
    priv_bad  = (cpl != '0);
    if (cls == CLS_CTRL) begin
      slot = (num == 3'd0) ? '0 : SLOT_W'(num - 3'd1);
    end else begin
      slot = (num >= 3'd6) ? SLOT_W'(num - 3'd2) : SLOT_W'(num);
    end
    ud = vld && !priv_bad && (cls == CLS_CTRL) && !cr_exists;
    gp = vld && (priv_bad
                 || ((cls == CLS_DBG) && gd_lock)
                 || ((cls == CLS_CTRL) && cr_exists && wr && (num == 3'd0) && cr0_bad));
  end
endmodule

// File: rtl/sysreg_wr_filter.sv
module sysreg_wr_filter
  import sysreg_pkg::*;
(
  input  reg_class_e        cls,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              cr0_bad
);
  always_comb begin
    cr0_bad = (din[CR0_PG] && !din[CR0_PE]) || (din[CR0_NW] && !din[CR0_CD]);
    dout    = din;
    if (cls == CLS_DBG) begin
      if (slot == SLOT_W'(DR_STAT_SLOT)) dout = din | STAT_ONES_MASK;
      else if (slot == SLOT_W'(DR_CTRL_SLOT)) dout = din & ~CTRL_ZERO_MASK;
    end
  end
endmodule

// File: rtl/sysreg_access_unit.sv
module sysreg_access_unit
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic              req_dbg,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [CPL_W-1:0]  req_cpl,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              flt_gp,
  output logic              flt_ud
);
  reg_class_e        cls;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] wdata_fix;
  logic              cr0_bad;
  logic              commit;
  logic [DATA_W-1:0] cr_q [NUM_CR];
  logic [DATA_W-1:0] dr_q [NUM_DR];

  assign cls = reg_class_e'(req_dbg);

  sysreg_wr_filter u_filt (
    .cls(cls), .slot(slot), .din(wr_data), .dout(wdata_fix), .cr0_bad(cr0_bad)
  );

  sysreg_decode u_dec (
    .vld(req_vld), .wr(req_wr), .cls(cls), .num(req_num), .cpl(req_cpl),
    .gd_lock(dr_q[DR_CTRL_SLOT][GD_BIT]), .cr0_bad(cr0_bad),
    .slot(slot), .gp(flt_gp), .ud(flt_ud)
  );

  assign commit = req_vld && req_wr && !flt_gp && !flt_ud;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CR; gi++) begin : g_cr
      logic en;
      assign en = commit && (cls == CLS_CTRL) && (slot == SLOT_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cr_q[gi] <= '0;
        else if (en) cr_q[gi] <= wdata_fix;
      end
    end
    for (gi = 0; gi < NUM_DR; gi++) begin : g_dr
      localparam logic [DATA_W-1:0] RST_V = (gi == DR_STAT_SLOT) ? STAT_ONES_MASK : '0;
      logic en;
      assign en = commit && (cls == CLS_DBG) && (slot == SLOT_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  dr_q[gi] <= RST_V;
        else if (en) dr_q[gi] <= wdata_fix;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (req_vld && !req_wr && !flt_gp && !flt_ud) begin
      if (cls == CLS_DBG) begin
        for (int i = 0; i < NUM_DR; i++) if (slot == SLOT_W'(i)) rd_data = dr_q[i];
      end else begin
        for (int i = 0; i < NUM_CR; i++) if (slot == SLOT_W'(i)) rd_data = cr_q[i];
      end
    end
  end

  // R1
  priv_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cpl != '0) |-> (flt_gp && !flt_ud && rd_data == '0));
  // R1
  fault_keeps_cr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_gp || flt_ud) |=> $stable(cr_q[0]));
  // R2
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_gp && flt_ud));
  // R6
  cr0_pg_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cr_q[0][CR0_PG] && !cr_q[0][CR0_PE]));
  // R7
  cr0_nw_cd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cr_q[0][CR0_NW] && !cr_q[0][CR0_CD]));
  // R8
  stat_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_q[DR_STAT_SLOT] & STAT_ONES_MASK) == STAT_ONES_MASK);
  // R9
  ctrl_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_q[DR_CTRL_SLOT] & CTRL_ZERO_MASK) == '0);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> (!flt_gp && !flt_ud && rd_data == '0));
endmodule

// File: tb/sysreg_access_unit_tb.sv
module sysreg_access_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_wr, req_dbg;
  logic [2:0]  req_num;
  logic [1:0]  req_cpl;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        flt_gp, flt_ud;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] m_cr [3];
  logic [31:0] m_dr [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_access_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr), .req_dbg(req_dbg),
    .req_num(req_num), .req_cpl(req_cpl), .wr_data(wr_data),
    .rd_data(rd_data), .flt_gp(flt_gp), .flt_ud(flt_ud)
  );

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, check outputs before posedge, update model.
  task automatic access(input string req, input logic dbg, input int num, input int cpl,
                        input logic wr, input logic [31:0] d);
    logic gp, ud, bad0;
    logic [31:0] rv;
    int s;
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_dbg = dbg;
    req_num = 3'(num); req_cpl = 2'(cpl); wr_data = d;
    gp = 1'b0; ud = 1'b0; rv = '0;
    bad0 = (d[31] && !d[0]) || (d[29] && !d[30]);
    if (!dbg) s = (num == 0) ? 0 : num - 1;
    else      s = (num >= 6) ? num - 2 : num;
    if (cpl != 0) gp = 1'b1;
    else if (!dbg && !(num == 0 || num == 2 || num == 3)) ud = 1'b1;
    else if (dbg && m_dr[5][13]) gp = 1'b1;
    else if (!dbg && wr && num == 0 && bad0) gp = 1'b1;
    if (!wr && !gp && !ud) rv = dbg ? m_dr[s] : m_cr[s];
    #1;
    chk(req, {rd_data, flt_gp, flt_ud}, {rv, gp, ud});
    @(posedge clk);
    if (wr && !gp && !ud) begin
      if (!dbg) m_cr[s] = d;
      else if (s == 4) m_dr[s] = d | 32'hFFFF_1FF0;
      else if (s == 5) m_dr[s] = d & ~32'h0000_DC00;
      else m_dr[s] = d;
    end
  endtask

  task automatic dump_all(input string req);
    for (int n = 0; n < 8; n++) access(req, 1'b0, n, 0, 1'b0, '0);
    for (int n = 0; n < 8; n++) access(req, 1'b1, n, 0, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_wr = 1'b0; req_dbg = 1'b0;
    req_num = '0; req_cpl = '0; wr_data = '0;
    for (int i = 0; i < 3; i++) m_cr[i] = '0;
    for (int i = 0; i < 6; i++) m_dr[i] = '0;
    m_dr[4] = 32'hFFFF_1FF0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R11 idle", {rd_data, flt_gp, flt_ud}, 34'd0);
    dump_all("R10 reset values");

    // R1 / R2 / R3 / R4 / R8 / R9: full sweep of class x number x privilege x direction
    for (int p = 3; p >= 0; p--)
      for (int c = 0; c < 2; c++)
        for (int n = 0; n < 8; n++) begin
          logic [31:0] d;
          d = 32'h1357_9BDF ^ (32'(n) * 32'h0101_0101) ^ (32'(p) << 20) ^ (32'(c) << 7);
          d[13] = 1'b0;
          if (!c && n == 0) d = 32'hE000_0001 ^ (32'(n + p) << 4);
          access(p != 0 ? "R1 privilege" : (c ? "R4 R8 R9 debug map" : "R2 R3 control map"),
                 c[0], n, p, 1'b1, d);
          access("R11 readback", c[0], n, p, 1'b0, '0);
        end
    dump_all("R3 R4 distinct slots");

    // R4: alias writes through 6/7, read through 4/5
    access("R4 R8 alias stat", 1'b1, 6, 0, 1'b1, 32'h0000_000F);
    access("R4 alias read",    1'b1, 4, 0, 1'b0, '0);
    access("R4 R9 alias ctrl", 1'b1, 7, 0, 1'b1, 32'hFFFF_DFFF);
    access("R4 alias read",    1'b1, 5, 0, 1'b0, '0);

    // R6 / R7: illegal mode-control pairs, then legal neighbours
    access("R6 pg without pe", 1'b0, 0, 0, 1'b1, 32'h8000_0000);
    access("R7 nw without cd", 1'b0, 0, 0, 1'b1, 32'h2000_0001);
    access("R6 R7 unchanged",  1'b0, 0, 0, 1'b0, '0);
    access("R6 R7 legal",      1'b0, 0, 0, 1'b1, 32'hE000_0001);
    access("R6 R7 legal rb",   1'b0, 0, 0, 1'b0, '0);
    access("R7 cd only",       1'b0, 0, 0, 1'b1, 32'h4000_0000);
    access("R7 cd only rb",    1'b0, 0, 0, 1'b0, '0);

    // R5: set lockout last, then sweep everything again
    access("R5 set lock", 1'b1, 7, 0, 1'b1, 32'h0000_2000);
    dump_all("R5 lockout");
    for (int n = 0; n < 8; n++) access("R5 locked write", 1'b1, n, 0, 1'b1, 32'h0);
    access("R5 control ok", 1'b0, 2, 0, 1'b1, 32'hCAFE_F00D);
    access("R5 control rb", 1'b0, 2, 0, 1'b0, '0);
    access("R1 over lock",  1'b1, 5, 2, 1'b0, '0);

    @(negedge clk); req_vld = 1'b0; #1;
    chk("R11 idle end", {rd_data, flt_gp, flt_ud}, 34'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule